// File: doc/BRIEF.md
# Ten-bit interval timer

The block is a free-running interval timer with a 10-bit count. A divide-by-12 prescaler inside the block turns the input clock into one advance of the count per machine cycle. Software starts the timer by writing a run bit in a control register. Writing that run bit as 0 halts the timer and returns both the count and the prescaler to zero.

When the count passes its highest value it wraps to zero and raises an overflow flag. The flag stays high until software writes a 1 to a clear bit in a separate command register. The block also holds two enable bits in an enable register: one for this timer and one global. Both must be set, together with the flag, for the block to request an interrupt. Vector selection and arbitration among sources take place outside the block.

Top module: `interval_timer10`

## Requirements
- R1: After reset the count is 0, the overflow flag is 0, the interrupt request is 0, the timer is stopped and both enable bits are 0.
- R2: A control write with bit 4 (run) set to 1 starts the timer. The count then advances by one every 12 clock cycles, and the first advance lands 12 clock edges after the write edge.
- R3: A control write with the run bit set to 1 while the timer is already running does not disturb the count or the prescaler phase.
- R4: A control write with the run bit set to 0 sets the count to 0 at the write edge and halts it. The prescaler restarts from zero, and the overflow flag is left unchanged.
- R5: An advance from count 1023 wraps the count to 0 and sets the overflow flag on that same edge.
- R6: A command write with bit 5 (clear) set to 1 clears the overflow flag at the write edge. A command write with bit 5 at 0 has no effect on the flag.
- R7: If an overflow and a clear command fall on the same edge, the flag is set after that edge.
- R8: The interrupt request is high exactly when the flag, the timer enable (enable register bit 4) and the global enable (enable register bit 7) are all 1. An enable write takes effect from its write edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data, bit 4 is the run bit |
| cmd_we | input | 1 | Command register write strobe |
| cmd_wdata | input | 8 | Command write data, bit 5 clears the flag |
| ien_we | input | 1 | Enable register write strobe |
| ien_wdata | input | 8 | Enable data, bit 7 global, bit 4 timer |
| count | output | 10 | Current timer count |
| ovf_flag | output | 1 | Overflow flag |
| irq | output | 1 | Qualified interrupt request |

## Verification
Each result has a fixed arrival time, counted in clock edges from the edge that captured the write. The count reads 0 at start+11 and 1 at start+12, and it reaches 0 again with the flag set at start+12288. A stop shows a zero count, and a clear or enable write shows its effect, on the write edge itself, because the irq output is combinational from registers. The driver tags every expected value with the absolute edge number at which it is due. The monitor compares it one nanosecond after the following falling edge. A clear command is aimed at the exact overflow edge by counting edges from the start.

// File: rtl/interval_timer10.sv
module interval_timer10 #(
  parameter int CNT_W   = 10,
  parameter int DIV     = 12,
  parameter int REG_W   = 8,
  parameter int RUN_POS = 4,
  parameter int CLR_POS = 5,
  parameter int GEN_POS = 7,
  parameter int TEN_POS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [REG_W-1:0] ctl_wdata,
  input  logic             cmd_we,
  input  logic [REG_W-1:0] cmd_wdata,
  input  logic             ien_we,
  input  logic [REG_W-1:0] ien_wdata,
  output logic [CNT_W-1:0] count,
  output logic             ovf_flag,
  output logic             irq
);
  localparam int               PW    = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0]    PLAST = PW'(DIV - 1);
  localparam logic [CNT_W-1:0] CLAST = '1;

  logic          run, en_g, en_t;
  logic [PW-1:0] presc;
  logic          stop_req, tick, wrap, clr;

  assign stop_req = ctl_we & ~ctl_wdata[RUN_POS];
  assign tick     = run & (presc == PLAST);
  assign wrap     = tick & (count == CLAST);
  assign clr      = cmd_we & cmd_wdata[CLR_POS];
  assign irq      = ovf_flag & en_g & en_t;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run      <= 1'b0;
      presc    <= '0;
      count    <= '0;
      ovf_flag <= 1'b0;
      en_g     <= 1'b0;
      en_t     <= 1'b0;
    end else begin
      if (ctl_we) run <= ctl_wdata[RUN_POS];
      if (stop_req || !run || tick) presc <= '0;
      else                          presc <= presc + PW'(1);
      if (stop_req)  count <= '0;
      else if (tick) count <= count + CNT_W'(1);
      if (wrap)     ovf_flag <= 1'b1;
      else if (clr) ovf_flag <= 1'b0;
      if (ien_we) begin
        en_g <= ien_wdata[GEN_POS];
        en_t <= ien_wdata[TEN_POS];
      end
    end
  end

  assert_presc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    presc <= PLAST);
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_we && !tick) |=> $stable(count));
  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !stop_req) |=> count == $past(count) + CNT_W'(1));
  assert_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> (count == '0));
  assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !stop_req) |=> (ovf_flag && count == '0));
  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !wrap) |=> !ovf_flag);
  assert_collide_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && wrap) |=> ovf_flag);
  assert_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_we && !ien_wdata[GEN_POS]) |=> !irq);
endmodule

// File: tb/sim_interval_timer10.sv
`timescale 1ns/1ps
module sim_interval_timer10;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_we = 1'b0, cmd_we = 1'b0, ien_we = 1'b0;
  logic [7:0] ctl_wdata = '0, cmd_wdata = '0, ien_wdata = '0;
  logic [9:0] count;
  logic       ovf_flag, irq;

  always #2 clk = ~clk;

  interval_timer10 u0 (
    .clk(clk), .rst_n(rst_n),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .ien_we(ien_we), .ien_wdata(ien_wdata),
    .count(count), .ovf_flag(ovf_flag), .irq(irq)
  );

  typedef struct {
    int    cyc;
    int    kind;
    int    val;
    string tag;
  } exp_t;

  exp_t q[$];
  int   cycnt = 0;
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done = 0;

  always @(posedge clk) cycnt <= cycnt + 1;

  task automatic expect_at(input int cyc, input int kind, input int val, input string tag);
    exp_t e;
    e.cyc = cyc; e.kind = kind; e.val = val; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic wait_to(input int c);
    while (cycnt < c) @(negedge clk);
  endtask

  task automatic wr(input int which, input logic [7:0] d, output int wedge);
    @(negedge clk);
    case (which)
      0: begin ctl_we = 1'b1; ctl_wdata = d; end
      1: begin cmd_we = 1'b1; cmd_wdata = d; end
      default: begin ien_we = 1'b1; ien_wdata = d; end
    endcase
    wedge = cycnt + 1;
    @(negedge clk);
    ctl_we = 1'b0; cmd_we = 1'b0; ien_we = 1'b0;
  endtask

  // monitor: compare every due item one ns after the falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0 && q[0].cyc <= cycnt) begin
        exp_t e;
        int act;
        e = q.pop_front();
        act = (e.kind == 0) ? int'(count) : (e.kind == 1) ? int'(ovf_flag) : int'(irq);
        n_cmp++;
        if (act != e.val) begin
          n_bad++;
          $display("FAIL %s at edge %0d kind %0d: actual %0d expected %0d",
                   e.tag, cycnt, e.kind, act, e.val);
        end
      end
    end
  end

  initial begin
    int s, w, e, p, s2, t;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    expect_at(cycnt + 1, 0, 0, "R1 count");
    expect_at(cycnt + 1, 1, 0, "R1 flag");
    expect_at(cycnt + 1, 2, 0, "R1 irq");
    wait_to(cycnt + 20);
    expect_at(cycnt + 1, 0, 0, "R1 idle count");
    wait_to(cycnt + 3);

    wr(0, 8'h10, s);
    expect_at(s + 11, 0, 0, "R2 before first step");
    expect_at(s + 12, 0, 1, "R2 first step");
    expect_at(s + 24, 0, 2, "R2 second step");
    wait_to(s + 30);
    wr(0, 8'h11, w);
    expect_at(w + 1, 0, (w + 1 - s) / 12, "R3 rewrite run");
    expect_at(s + 120, 0, 10, "R3 phase kept");
    expect_at(s + 12287, 1, 0, "R5 flag before wrap");
    expect_at(s + 12287, 0, 1023, "R5 count at top");
    expect_at(s + 12288, 0, 0, "R5 wrap count");
    expect_at(s + 12288, 1, 1, "R5 flag set");
    expect_at(s + 12288, 2, 0, "R8 no enables");
    wait_to(s + 12290);

    wr(2, 8'h80, e);
    expect_at(e, 2, 0, "R8 global only");
    wr(2, 8'h10, e);
    expect_at(e, 2, 0, "R8 timer only");
    wr(2, 8'h90, e);
    expect_at(e, 2, 1, "R8 both enabled");
    wr(1, 8'hDF, e);
    expect_at(e, 1, 1, "R6 other bits ignored");
    wr(1, 8'h20, e);
    expect_at(e, 1, 0, "R6 clear");
    expect_at(e, 2, 0, "R8 irq drops with flag");

    t = s + 24576;
    wait_to(t - 2);
    wr(1, 8'h20, e);
    expect_at(e, 1, 1, "R7 set wins");
    expect_at(e, 0, 0, "R7 wrap count");
    expect_at(e, 2, 1, "R7 irq");
    expect_at(e + 1, 1, 1, "R7 flag held");
    wait_to(e + 40);

    wr(0, 8'h00, p);
    expect_at(p, 0, 0, "R4 stop zeroes");
    expect_at(p, 1, 1, "R4 flag kept");
    expect_at(p + 30, 0, 0, "R4 stays halted");
    wait_to(p + 31);

    wr(0, 8'h10, s2);
    wait_to(s2 + 17);
    wr(0, 8'h00, p);
    expect_at(p, 0, 0, "R4 mid-phase stop");
    wr(0, 8'h10, s2);
    expect_at(s2 + 11, 0, 0, "R4 prescaler restarted");
    expect_at(s2 + 12, 0, 1, "R4 first step after restart");
    wait_to(s2 + 13);
    wr(2, 8'h10, e);
    expect_at(e, 2, 0, "R8 global off");

    wait (q.size() == 0);
    @(negedge clk);
    #2;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule